// File: doc/BRIEF.md
# Read-to-Write Turnaround Command Gate

This block sits between an upstream command generator and the command bus of a DDR SDRAM. Each cycle the generator presents a request: nothing, a read or a write. Reads pass straight through. The gate keeps track of whether a read burst still owns the data bus and the strobe. It counts the CAS latency plus the data beats of that burst.

A write that arrives while a read is still in flight is not sent at once. The gate first issues a burst-stop command, which ends the read and releases the data bus. It then holds the write for the whole-cycle turnaround latency and issues it afterwards. During the wait it raises a stall so the generator knows its request is pending. The bus-drive enable rises with the write itself, which tells the controller's data path it may drive data and strobe. A read that was issued with auto-precharge must never be cut short. A write aimed at such a read is dropped, and the gate flags it as an illegal sequence.

The CAS latency is given as a code in half-cycle units and the burst length in beats. The gate rounds both to whole clock cycles.

Top module: `rw_turn_gate`

## Requirements
- R1: While rstN is low, cmdOut is NOP (2'b00) and stall, busDrive and illegal are low, whatever is requested. Requests sampled during reset have no effect after it is released.
- R2: Request codes are 2'b00 none, 2'b01 read, 2'b10 write and 2'b11 none. Command codes are 2'b00 NOP, 2'b01 READ, 2'b10 WRITE and 2'b11 burst stop. A read request sampled at a clock edge appears as READ on cmdOut right after that edge. Every cycle with no command issued shows NOP.
- R3: The turnaround latency L in cycles is casCode/2 rounded up, with codes 0 and 1 treated as 1 cycle. For example, code 4 gives 2, code 5 gives 3 and code 6 gives 3.
- R4: A read stays in flight for W = L + ceil(burstLen/2) clock edges after the edge that issued it. Take a write request sampled at the j-th following edge, with 1 <= j <= W, behind a read without auto-precharge. That write produces a burst stop (2'b11) in that cycle and raises stall.
- R5: A write request sampled while no read is in flight is issued as WRITE after that edge, with no burst stop before it.
- R6: After a burst stop, WRITE follows exactly L cycles later and only NOP is driven in between. Stall is high from the burst-stop cycle through the cycle before the WRITE and low in the WRITE cycle.
- R7: Requests sampled while stall is high are ignored. No READ and no extra WRITE results from them.
- R8: Take a write sampled while a read with reqAutoPre set is in flight. It raises illegal for that one cycle with cmdOut NOP and stall low, and the write is discarded. The read window is not shortened: a second write inside the window is again illegal, and one after it passes.
- R9: busDrive rises only in a cycle where cmdOut is WRITE. It stays high for ceil(burstLen/2) cycles counting that one, and each further WRITE restarts that count.

Ports table: one row per port of `rw_turn_gate`, in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqCmd | input | 2 | Requested command from the generator |
| reqAutoPre | input | 1 | Auto-precharge flag attached to a read request |
| casCode | input | CL_W | CAS latency in half-cycle units |
| burstLen | input | BL_W | Burst length in data beats |
| cmdOut | output | 2 | Command driven to the memory |
| stall | output | 1 | A write is held and waits for turnaround |
| busDrive | output | 1 | The controller may drive data and strobe |
| illegal | output | 1 | One-cycle flag for a write aimed at an auto-precharge read |

## Verification
The hardest case to reach is a write that lands on the last edge of the read window, or just past it. Whether a burst stop appears there depends on the latency code and the burst length together. The bench sweeps every latency code, three burst lengths and both auto-precharge settings. For each combination it places the write at every distance from the read, from one edge up to one past the window, and predicts the burst-stop position, the wait length and the drive window from the rounding rules. During each turnaround wait it also keeps presenting read requests, to show that they are swallowed.

// File: rtl/rw_turn_pkg.sv
package rw_turn_pkg;

  typedef enum logic [1:0] {
    REQ_NONE  = 2'b00,
    REQ_READ  = 2'b01,
    REQ_WRITE = 2'b10,
    REQ_SPARE = 2'b11
  } req_e;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_BST   = 2'b11
  } cmd_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } state_e;

  typedef struct packed {
    logic loadRd;
    logic clrRd;
    logic armWait;
    logic startDrive;
  } strobe_t;

endpackage

// File: rtl/rw_turn_downcnt.sv
module rw_turn_downcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (load) begin
      count <= loadVal;
    end else if (count != '0) begin
      count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/rw_turn_dp.sv
module rw_turn_dp
  import rw_turn_pkg::*;
#(
  parameter int CL_W  = 3,
  parameter int BL_W  = 4,
  parameter int CNT_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [CL_W-1:0] casCode,
  input  logic [BL_W-1:0] burstLen,
  input  strobe_t         stb,
  output logic            readActive,
  output logic            waitLast,
  output logic            busDrive
);

  localparam int NCNT   = 3;
  localparam int IDX_RD = 0;
  localparam int IDX_WT = 1;
  localparam int IDX_DV = 2;

  // whole-cycle latency: half-cycle code rounded up, never below one
  logic [CL_W:0]  casRound;
  logic [CNT_W-1:0] latWhole;
  assign casRound = ({1'b0, casCode} + 1'b1) >> 1;
  assign latWhole = (casRound == '0) ? CNT_W'(1) : CNT_W'(casRound);

  // clock cycles occupied by the data beats, rounded up, never below one
  logic [BL_W:0]    beatRound;
  logic [CNT_W-1:0] halfBurst;
  assign beatRound = ({1'b0, burstLen} + 1'b1) >> 1;
  assign halfBurst = (beatRound == '0) ? CNT_W'(1) : CNT_W'(beatRound);

  logic [CNT_W-1:0] rdWindow;
  assign rdWindow = latWhole + halfBurst;

  logic [CNT_W-1:0] cntLoadVal [NCNT];
  logic             cntLoad    [NCNT];
  logic             cntClr     [NCNT];
  logic [CNT_W-1:0] cntVal     [NCNT];

  always_comb begin
    cntLoadVal[IDX_RD] = rdWindow;
    cntLoad[IDX_RD]    = stb.loadRd;
    cntClr[IDX_RD]     = stb.clrRd;
    cntLoadVal[IDX_WT] = latWhole;
    cntLoad[IDX_WT]    = stb.armWait;
    cntClr[IDX_WT]     = 1'b0;
    cntLoadVal[IDX_DV] = halfBurst;
    cntLoad[IDX_DV]    = stb.startDrive;
    cntClr[IDX_DV]     = 1'b0;
  end

  generate
    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
      rw_turn_downcnt #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rstN   (rstN),
        .clear  (cntClr[g]),
        .load   (cntLoad[g]),
        .loadVal(cntLoadVal[g]),
        .count  (cntVal[g])
      );
    end
  endgenerate

  assign readActive = (cntVal[IDX_RD] != '0);
  assign waitLast   = (cntVal[IDX_WT] == CNT_W'(1));
  assign busDrive   = (cntVal[IDX_DV] != '0);

endmodule

// File: rtl/rw_turn_ctrl.sv
module rw_turn_ctrl
  import rw_turn_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] reqCmd,
  input  logic       reqAutoPre,
  input  logic       readActive,
  input  logic       waitLast,
  output strobe_t    stb,
  output logic [1:0] cmdOut,
  output logic       stall,
  output logic       illegal
);

  state_e state, nextState;
  cmd_e   cmdReg, nextCmd;
  logic   stallReg, nextStall;
  logic   illegalReg, nextIllegal;
  logic   apReg, nextAp;
  req_e   req;

  assign req = req_e'(reqCmd);

  always_comb begin
    nextState   = state;
    nextCmd     = CMD_NOP;
    nextStall   = 1'b0;
    nextIllegal = 1'b0;
    nextAp      = apReg;
    stb         = '0;
    unique case (state)
      ST_IDLE: begin
        if (req == REQ_READ) begin
          nextCmd    = CMD_READ;
          nextAp     = reqAutoPre;
          stb.loadRd = 1'b1;
        end else if (req == REQ_WRITE) begin
          if (readActive && apReg) begin
            nextIllegal = 1'b1;
          end else if (readActive) begin
            nextCmd     = CMD_BST;
            nextStall   = 1'b1;
            nextState   = ST_HOLD;
            stb.clrRd   = 1'b1;
            stb.armWait = 1'b1;
          end else begin
            nextCmd        = CMD_WRITE;
            stb.startDrive = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (waitLast) begin
          nextCmd        = CMD_WRITE;
          nextState      = ST_IDLE;
          stb.startDrive = 1'b1;
        end else begin
          nextStall = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cmdReg     <= CMD_NOP;
      stallReg   <= 1'b0;
      illegalReg <= 1'b0;
      apReg      <= 1'b0;
    end else begin
      state      <= nextState;
      cmdReg     <= nextCmd;
      stallReg   <= nextStall;
      illegalReg <= nextIllegal;
      apReg      <= nextAp;
    end
  end

  assign cmdOut  = cmdReg;
  assign stall   = stallReg;
  assign illegal = illegalReg;

endmodule

// File: rtl/rw_turn_gate.sv
module rw_turn_gate
  import rw_turn_pkg::*;
#(
  parameter int CL_W = 3,
  parameter int BL_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      reqCmd,
  input  logic            reqAutoPre,
  input  logic [CL_W-1:0] casCode,
  input  logic [BL_W-1:0] burstLen,
  output logic [1:0]      cmdOut,
  output logic            stall,
  output logic            busDrive,
  output logic            illegal
);

  localparam int MAX_LAT  = ((1 << CL_W) + 1) / 2;
  localparam int MAX_HALF = ((1 << BL_W) + 1) / 2;
  localparam int CNT_W    = $clog2(MAX_LAT + MAX_HALF + 1);

  strobe_t stb;
  logic    readActive;
  logic    waitLast;

  rw_turn_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqCmd    (reqCmd),
    .reqAutoPre(reqAutoPre),
    .readActive(readActive),
    .waitLast  (waitLast),
    .stb       (stb),
    .cmdOut    (cmdOut),
    .stall     (stall),
    .illegal   (illegal)
  );

  rw_turn_dp #(
    .CL_W (CL_W),
    .BL_W (BL_W),
    .CNT_W(CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .casCode   (casCode),
    .burstLen  (burstLen),
    .stb       (stb),
    .readActive(readActive),
    .waitLast  (waitLast),
    .busDrive  (busDrive)
  );

endmodule

// File: rtl/rw_turn_chk.sv
module rw_turn_chk
  import rw_turn_pkg::*;
#(
  parameter int CL_W = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic [CL_W-1:0] casCode,
  input logic [1:0]      cmdOut,
  input logic            stall,
  input logic            busDrive,
  input logic            illegal
);

  logic [7:0] gapCnt;
  logic [7:0] latHold;
  logic       armed;
  logic [7:0] latNow;

  assign latNow = (casCode < CL_W'(2)) ? 8'd1 : 8'((int'(casCode) + 1) / 2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt  <= '0;
      latHold <= '0;
      armed   <= 1'b0;
    end else if (cmdOut == CMD_BST) begin
      armed   <= 1'b1;
      gapCnt  <= 8'd1;
      latHold <= latNow;
    end else if (armed) begin
      if (cmdOut == CMD_WRITE) armed <= 1'b0;
      else gapCnt <= gapCnt + 8'd1;
    end
  end

  p_bst_stalls_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == CMD_BST) |-> stall);

  p_gap_exact_r6: assert property (@(posedge clk) disable iff (!rstN)
    (armed && cmdOut == CMD_WRITE) |-> (gapCnt == latHold));

  p_release_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |-> (cmdOut == CMD_WRITE));

  p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (cmdOut == CMD_NOP || cmdOut == CMD_BST));

  p_illegal_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (cmdOut == CMD_NOP && !stall));

  p_write_drives_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == CMD_WRITE) |-> busDrive);

  p_drive_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busDrive) |-> (cmdOut == CMD_WRITE));

endmodule

bind rw_turn_gate rw_turn_chk #(.CL_W(CL_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .casCode (casCode),
  .cmdOut  (cmdOut),
  .stall   (stall),
  .busDrive(busDrive),
  .illegal (illegal)
);

// File: tb/rw_turn_gate_test.sv
module rw_turn_gate_test;
  import rw_turn_pkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] reqCmd = 2'b00;
  logic       reqAutoPre = 1'b0;
  logic [2:0] casCode = 3'd4;
  logic [3:0] burstLen = 4'd4;
  logic [1:0] cmdOut;
  logic       stall, busDrive, illegal;
  int         vecs = 0;
  int         errs = 0;

  rw_turn_gate uut (
    .clk(clk), .rstN(rstN), .reqCmd(reqCmd), .reqAutoPre(reqAutoPre),
    .casCode(casCode), .burstLen(burstLen), .cmdOut(cmdOut),
    .stall(stall), .busDrive(busDrive), .illegal(illegal)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input logic [1:0] c, input logic ap);
    reqCmd = c;
    reqAutoPre = ap;
    @(posedge clk);
    #1;
  endtask

  task automatic driveTail(input int half);
    for (int n = 1; n < half; n++) begin
      tick(REQ_NONE, 1'b0);
      check("R9 drive held", int'(busDrive), 1);
    end
    tick(REQ_NONE, 1'b0);
    check("R9 drive ends", int'(busDrive), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    reqCmd = REQ_WRITE;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset cmd", int'(cmdOut), int'(CMD_NOP));
    check("R1 reset stall", int'(stall), 0);
    check("R1 reset drive", int'(busDrive), 0);
    check("R1 reset illegal", int'(illegal), 0);
    rstN = 1'b1;
    tick(REQ_NONE, 1'b0);
    check("R1 after reset", int'(cmdOut), int'(CMD_NOP));

    for (int code = 0; code < 8; code++) begin
      for (int bs = 0; bs < 3; bs++) begin
        for (int ap = 0; ap < 2; ap++) begin
          int lat, half, win;
          lat  = (code < 2) ? 1 : (code + 1) / 2;
          half = ((2 << bs) + 1) / 2;
          win  = lat + half;
          for (int j = 1; j <= win + 1; j++) begin
            casCode  = 3'(code);
            burstLen = 4'(2 << bs);
            repeat (16) tick(REQ_NONE, 1'b0);
            check("R2 idle nop", int'(cmdOut), int'(CMD_NOP));
            tick(REQ_READ, 1'(ap));
            check("R2 read issued", int'(cmdOut), int'(CMD_READ));
            for (int n = 1; n < j; n++) begin
              tick(REQ_NONE, 1'b0);
              check("R2 gap nop", int'(cmdOut), int'(CMD_NOP));
            end
            tick(REQ_WRITE, 1'b0);
            if (j <= win && ap == 1) begin
              int pos;
              check("R8 flag", int'(illegal), 1);
              check("R8 no cmd", int'(cmdOut), int'(CMD_NOP));
              check("R8 no stall", int'(stall), 0);
              pos = j;
              tick(REQ_NONE, 1'b0);
              pos++;
              check("R8 one cycle", int'(illegal), 0);
              while (pos < win - 1) begin
                tick(REQ_NONE, 1'b0);
                pos++;
              end
              if (pos == win - 1) begin
                tick(REQ_WRITE, 1'b0);
                pos++;
                check("R8 window kept", int'(illegal), 1);
              end
              tick(REQ_WRITE, 1'b0);
              check("R8 write after window", int'(cmdOut), int'(CMD_WRITE));
              check("R5 direct drive", int'(busDrive), 1);
              driveTail(half);
            end else if (j <= win) begin
              check("R4 burst stop", int'(cmdOut), int'(CMD_BST));
              check("R4 stall up", int'(stall), 1);
              check("R9 no early drive", int'(busDrive), 0);
              for (int n = 1; n < lat; n++) begin
                tick(REQ_READ, 1'b0);
                check("R7 request ignored", int'(cmdOut), int'(CMD_NOP));
                check("R6 stall held", int'(stall), 1);
                check("R9 no early drive", int'(busDrive), 0);
              end
              tick(REQ_NONE, 1'b0);
              check("R3 R6 write after latency", int'(cmdOut), int'(CMD_WRITE));
              check("R6 stall released", int'(stall), 0);
              check("R9 drive with write", int'(busDrive), 1);
              driveTail(half);
              check("R7 no late read", int'(cmdOut), int'(CMD_NOP));
            end else begin
              check("R5 direct write", int'(cmdOut), int'(CMD_WRITE));
              check("R5 no stall", int'(stall), 0);
              check("R9 drive with write", int'(busDrive), 1);
              driveTail(half);
            end
          end
        end
      end
    end

    for (int bs = 0; bs < 3; bs++) begin
      burstLen = 4'(2 << bs);
      repeat (16) tick(REQ_NONE, 1'b0);
      tick(REQ_WRITE, 1'b0);
      check("R5 first write", int'(cmdOut), int'(CMD_WRITE));
      tick(REQ_WRITE, 1'b0);
      check("R5 second write", int'(cmdOut), int'(CMD_WRITE));
      check("R9 drive restart", int'(busDrive), 1);
      driveTail(bs == 0 ? 1 : (2 << bs) / 2);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule